// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial control bus (I2C). It holds eight byte-wide configuration registers at bus addresses 0x01 through 0x08. It runs entirely in the system clock domain. The bus clock and data lines pass through a small synchronizer, and every bus event is then decoded from edges of the synchronized levels. The block answers to a 7-bit target address. The upper four bits of that address are fixed and the lower three come from strap pins, so up to eight copies can share one bus.

A write transfer works as follows. The first byte after the address loads an internal register pointer. Each byte after that is stored at the pointer, and the pointer then moves on. A read transfer first sets the pointer with a short write, then issues a repeated start with the direction bit set. The target returns bytes from successive registers for as long as the controller acknowledges them. The pointer stops advancing once it reaches the last register.

The parallel register contents are available on an output port. A separate single-cycle strobe fires whenever a byte with its least significant bit set is written to the last register. Downstream logic can use this strobe to take a coherent copy of the whole configuration at once.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset all eight registers read 0x00, the SDA pull-down is released and the update strobe is low.
- R2: The target acknowledges, by pulling SDA low during the ninth clock, only an address byte whose upper seven bits equal binary 1101 followed by the strap pins (strap bit 2 nearest the MSB) and whose last bit is 0 (write) or 1 (read). Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R3: In a write transfer the first byte after the address sets the pointer. Each later byte, received MSB first, is stored in the register at the pointer, and the pointer then advances by one. Every such byte is acknowledged.
- R4: The pointer stops at 0x08. Further bytes in a write overwrite register 0x08, and further reads return register 0x08 again.
- R5: Bytes written while the pointer is outside 0x01..0x08 are acknowledged but leave every register unchanged. A pointer below 0x01 still advances.
- R6: After the pointer is set and a repeated start is sent with the read bit, the target shifts out the register at the pointer MSB first. It changes SDA only while SCL is low, moves to the next register after each controller acknowledge, and releases SDA once a not-acknowledge is received.
- R7: A read at an unimplemented pointer below 0x01 returns 0x00.
- R8: A byte written to register 0x08 with bit 0 set raises the update strobe for exactly one system clock cycle. A byte with bit 0 clear raises no strobe.
- R9: A stop condition at any point ends the transfer and releases SDA. A byte cut short by a stop changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 3 | Low three bits of the target address |
| regs_o | output | 64 | Register contents; address 0x01+i occupies bits 8i+7..8i |
| commit_o | output | 1 | One-cycle update strobe |

## Verification
The bench builds the block with its default parameters: eight registers based at 0x01, a two-flop synchronizer, and strap pins tied to 011. That gives a target address of 0x6B, so the bench can also present a neighbouring strap address and one with a wrong fixed part. Each bus quarter period is eight system clocks. This keeps the synchronizer latency well inside each SCL phase, while transfers stay short enough to sweep the pointer across both ends of the register range. The bench runs writes that cross the 0x08 ceiling, writes at pointers 0x00 and 0x20, reads that saturate, a byte aborted by a stop, and strobe and no-strobe writes to the last register.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WBYTE,
        PH_ACK,
        PH_RBYTE,
        PH_RACK
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        logic [3:0]  bitcnt;
        logic [7:0]  shreg;
        logic [7:0]  ptr;
        logic        have_ptr;
        logic        to_read;
        logic        nack;
        logic        oe;
    } link_s;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] prev_o
);
    // STAGES flops of synchronization plus one flop holding the previous level
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic [W-1:0] src_d;
        if (k == 0) begin : g_first
            assign src_d = d_i;
        end else begin : g_next
            assign src_d = chain_q[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[k] <= '1;
            else        chain_q[k] <= src_d;
        end
    end

    assign q_o    = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
    parameter int NUM_REGS   = 8,
    parameter int BASE_ADDR  = 1,
    parameter int COMMIT_OFS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [7:0]            wr_addr_i,
    input  logic [7:0]            wr_data_i,
    input  logic [7:0]            rd_addr_i,
    output logic [7:0]            rd_data_o,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic                  commit_o
);
    localparam logic [7:0] COMMIT_ADDR = 8'(BASE_ADDR + COMMIT_OFS);

    logic commit_d, commit_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] MY_ADDR = 8'(BASE_ADDR + g);
        logic [7:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en_i && (wr_addr_i == MY_ADDR)) val_d = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= 8'h00;
            else        val_q <= val_d;
        end

        assign regs_o[g*8 +: 8] = val_q;
    end

    // read mux: unimplemented addresses return zero
    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_i == 8'(BASE_ADDR + i)) rd_data_o = regs_o[i*8 +: 8];
        end
    end

    always_comb begin
        commit_d = wr_en_i && (wr_addr_i == COMMIT_ADDR) && wr_data_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= commit_d;
    end

    assign commit_o = commit_q;
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         BASE_ADDR   = 1,
    parameter int         COMMIT_OFS  = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_HI     = 4'b1101
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [2:0]            strap_i,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic                  commit_o
);
    localparam logic [7:0] LAST_PTR = 8'(BASE_ADDR + NUM_REGS - 1);

    function automatic logic [7:0] step_ptr(input logic [7:0] p);
        return (p >= LAST_PTR) ? p : p + 8'd1;
    endfunction

    // ---- synchronization and bus event decode
    logic [1:0] pins_now, pins_prev;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({scl_i, sda_i}),
        .q_o    (pins_now),
        .prev_o (pins_prev)
    );

    assign scl_s    = pins_now[1];
    assign sda_s    = pins_now[0];
    assign scl_rise = scl_s & ~pins_prev[1];
    assign scl_fall = ~scl_s & pins_prev[1];
    assign start_ev = scl_s & pins_prev[1] & ~sda_s & pins_prev[0];
    assign stop_ev  = scl_s & pins_prev[1] & sda_s & ~pins_prev[0];

    // ---- register bank
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data, nxt_ptr;

    cfg_regbank #(
        .NUM_REGS   (NUM_REGS),
        .BASE_ADDR  (BASE_ADDR),
        .COMMIT_OFS (COMMIT_OFS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o),
        .commit_o  (commit_o)
    );

    // ---- protocol engine
    link_s c_d, c_q;

    always_comb begin
        c_d     = c_q;
        wr_en   = 1'b0;
        wr_addr = c_q.ptr;
        wr_data = c_q.shreg;
        rd_addr = c_q.ptr;
        nxt_ptr = step_ptr(c_q.ptr);

        if (start_ev) begin
            c_d.phase    = PH_ADDR;
            c_d.bitcnt   = 4'd0;
            c_d.have_ptr = 1'b0;
            c_d.oe       = 1'b0;
        end else if (stop_ev) begin
            c_d.phase = PH_IDLE;
            c_d.oe    = 1'b0;
        end else begin
            case (c_q.phase)
                PH_ADDR, PH_WBYTE: begin
                    if (scl_rise) begin
                        c_d.shreg  = {c_q.shreg[6:0], sda_s};
                        c_d.bitcnt = c_q.bitcnt + 4'd1;
                    end else if (scl_fall && (c_q.bitcnt == 4'd8)) begin
                        c_d.bitcnt = 4'd0;
                        if (c_q.phase == PH_ADDR) begin
                            if (c_q.shreg[7:1] == {ADDR_HI, strap_i}) begin
                                c_d.phase   = PH_ACK;
                                c_d.oe      = 1'b1;
                                c_d.to_read = c_q.shreg[0];
                            end else begin
                                c_d.phase = PH_IDLE;
                            end
                        end else begin
                            c_d.phase   = PH_ACK;
                            c_d.oe      = 1'b1;
                            c_d.to_read = 1'b0;
                            if (!c_q.have_ptr) begin
                                c_d.ptr      = c_q.shreg;
                                c_d.have_ptr = 1'b1;
                            end else begin
                                wr_en   = 1'b1;
                                c_d.ptr = nxt_ptr;
                            end
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        c_d.bitcnt = 4'd0;
                        if (c_q.to_read) begin
                            c_d.phase = PH_RBYTE;
                            c_d.shreg = rd_data;
                            c_d.oe    = ~rd_data[7];
                        end else begin
                            c_d.phase = PH_WBYTE;
                            c_d.oe    = 1'b0;
                        end
                    end
                end
                PH_RBYTE: begin
                    if (scl_fall) begin
                        if (c_q.bitcnt == 4'd7) begin
                            c_d.phase  = PH_RACK;
                            c_d.oe     = 1'b0;
                            c_d.bitcnt = 4'd0;
                        end else begin
                            c_d.bitcnt = c_q.bitcnt + 4'd1;
                            c_d.shreg  = {c_q.shreg[6:0], 1'b0};
                            c_d.oe     = ~c_q.shreg[6];
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        c_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (c_q.nack) begin
                            c_d.phase = PH_IDLE;
                        end else begin
                            c_d.ptr   = nxt_ptr;
                            rd_addr   = nxt_ptr;
                            c_d.shreg = rd_data;
                            c_d.oe    = ~rd_data[7];
                            c_d.phase = PH_RBYTE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sda_oe_o = c_q.oe;
endmodule

module i2c_cfg_target_chk #(
    parameter int NUM_REGS  = 8,
    parameter int BASE_ADDR = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  sda_s,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs,
    input logic                  commit,
    input logic                  wr_en,
    input logic [7:0]            wr_addr
);
    localparam logic [7:0] LO = 8'(BASE_ADDR);
    localparam logic [7:0] HI = 8'(BASE_ADDR + NUM_REGS - 1);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (regs == '0 && !sda_oe && !commit));

    assert_drive_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    assert_regs_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> $past(wr_en));

    assert_discard_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < LO || wr_addr > HI)) |=> $stable(regs));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_strobe_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(wr_en));

    assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $rose(sda_s)) |=> !sda_oe);
endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(
    .NUM_REGS  (NUM_REGS),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .sda_oe  (sda_oe_o),
    .regs    (regs_o),
    .commit  (commit_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;
    localparam int         NREG  = 8;
    localparam logic [2:0] STRAP = 3'b011;
    localparam logic [6:0] MYDEV = {4'b1101, STRAP};
    localparam int         Q     = 8;

    typedef struct packed {
        logic [6:0] dev;
        logic [7:0] ptr;
        logic [1:0] n;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{7'h6B, 8'h01, 2'd3, 8'hA5, 8'h3C, 8'h7E},
        '{7'h6B, 8'h06, 2'd3, 8'h11, 8'h22, 8'hC4},
        '{7'h6A, 8'h02, 2'd1, 8'hEE, 8'h00, 8'h00},
        '{7'h6B, 8'h07, 2'd3, 8'h55, 8'h81, 8'hF0},
        '{7'h6B, 8'h00, 2'd2, 8'h99, 8'h42, 8'h00},
        '{7'h6B, 8'h20, 2'd2, 8'h13, 8'h37, 8'h00},
        '{7'h4B, 8'h04, 2'd1, 8'hAA, 8'h00, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sda_oe, commit;
    logic [NREG*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_cfg_target uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .strap_i  (STRAP),
        .regs_o   (regs),
        .commit_o (commit)
    );

    int checks = 0, fails = 0, pulses = 0, exp_pulses = 0;
    bit finished = 0;
    logic [7:0] model [1:8];

    always @(posedge clk) if (rst_n && commit) pulses++;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] r;
        for (int i = 1; i <= 8; i++) r[(i-1)*8 +: 8] = model[i];
        return r;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] p);
        return (p >= 8'd1 && p <= 8'd8) ? model[p[3:0]] : 8'h00;
    endfunction

    function automatic logic [7:0] step(input logic [7:0] p);
        return (p >= 8'd8) ? p : p + 8'd1;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = ~sda_bus;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b = {b[6:0], sda_bus};
            tick(Q);
            scl = 1'b0;
        end
        tick(Q);
        sda_m = ~give_ack; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input vec_t v);
        logic ack;
        logic [7:0] p, d;
        bit match;
        match = (v.dev == MYDEV);
        bus_start();
        send_byte({v.dev, 1'b0}, ack);
        check("R2 address acknowledge", {63'd0, ack}, {63'd0, match});
        if (ack) begin
            send_byte(v.ptr, ack);
            check("R3 pointer byte ack", {63'd0, ack}, 64'd1);
            p = v.ptr;
            for (int k = 0; k < int'(v.n); k++) begin
                d = (k == 0) ? v.d0 : (k == 1) ? v.d1 : v.d2;
                send_byte(d, ack);
                check("R5 data byte ack", {63'd0, ack}, 64'd1);
                if (p >= 8'd1 && p <= 8'd8) model[p[3:0]] = d;
                if (p == 8'd8 && d[0]) exp_pulses++;
                p = step(p);
            end
        end
        bus_stop();
        tick(Q);
        check("R3 R4 R5 register contents", regs, model_flat());
        check("R8 strobe count", 64'(pulses), 64'(exp_pulses));
    endtask

    task automatic do_read(input logic [7:0] ptr, input int n);
        logic ack;
        logic [7:0] b, p;
        bus_start();
        send_byte({MYDEV, 1'b0}, ack);
        send_byte(ptr, ack);
        bus_start();
        send_byte({MYDEV, 1'b1}, ack);
        check("R2 read address ack", {63'd0, ack}, 64'd1);
        p = ptr;
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            check("R6 R4 R7 read byte", {56'd0, b}, {56'd0, model_rd(p)});
            p = step(p);
        end
        check("R6 SDA released after not-acknowledge", {63'd0, sda_oe}, 64'd0);
        bus_stop();
        tick(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic ack;
        for (int i = 1; i <= 8; i++) model[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        check("R1 registers after reset", regs, 64'd0);
        check("R1 SDA released", {63'd0, sda_oe}, 64'd0);
        check("R1 strobe low", {63'd0, commit}, 64'd0);

        for (int v = 0; v < 7; v++) do_write(VECS[v]);

        // R6/R7 reads, including saturation (R4) and low unimplemented pointer
        do_read(8'h02, 3);
        do_read(8'h07, 3);
        do_read(8'h00, 2);

        // R9 byte cut short by a stop
        bus_start();
        send_byte({MYDEV, 1'b0}, ack);
        send_byte(8'h03, ack);
        for (int i = 0; i < 4; i++) clock_bit(1'b1);
        bus_stop();
        tick(Q);
        check("R9 partial byte discarded", regs, model_flat());
        check("R9 SDA released after stop", {63'd0, sda_oe}, 64'd0);
        do_write('{MYDEV, 8'h03, 2'd1, 8'h5A, 8'h00, 8'h00});

        // R8 strobe on bit 0 set and not on bit 0 clear
        do_write('{MYDEV, 8'h08, 2'd1, 8'h01, 8'h00, 8'h00});
        do_write('{MYDEV, 8'h08, 2'd1, 8'h00, 8'h00, 8'h00});
        check("R8 strobe idle at end", {63'd0, commit}, 64'd0);

        finish_run();
    end
endmodule